// File: doc/BRIEF.md
# I2C Quick-Command and Bus-Recovery Sequencer

This block drives the two open-drain lines of an I2C bus directly, through output enables, and issues a zero-length transaction. It waits for an idle bus, sends a START, clocks out a 7-bit target address followed by the read/write bit, samples one acknowledge bit and closes with a STOP. The result is reported as acknowledged, not acknowledged, or a stuck-bus error. Every phase length is given in nanoseconds for a standard-speed set and a fast set. These lengths are turned into clock cycles at elaboration. Whenever the block releases SCL, it waits for the line to read high before it times the high phase, so a target that holds the clock low (clock stretching) is tolerated up to a cycle limit.

A second request starts a recovery sequence that never drives SDA. It releases both lines and checks whether the bus is free. If it is not, it pulses SCL a bounded number of times and checks the lines again after each pulse. A request marked as ten-bit is refused at once with its own error code, and the bus is left untouched.

Top module: `i2cq_seq`

## Requirements
- R1: While reset is held, and after it, both output enables are 0 (lines released), and done_o, ack_o and err_o are 0.
- R2: Before a START, both lines are released. The block waits until both read high, then for the bus-free time. If they are not high within STRETCH_CYC cycles, it ends with err_o=1 and err_code_o=2'b01 (stuck bus).
- R3: A START is made by pulling SDA low while SCL is released and high, for the hold-after-START time. Exactly one START is seen on the bus per accepted quick command.
- R4: The byte {addr_i, rw_i} is sent MSB first. SDA changes only while the block holds SCL low: the first half of the low time keeps the previous SDA level, and the second half presents the new bit.
- R5: After each SCL release, the block waits for SCL to read high before it times the high phase. If SCL stays low for STRETCH_CYC cycles, it releases both lines and ends with err_o=1 and err_code_o=2'b01.
- R6: In the ninth clock, SDA is released and sampled once SCL reads high. Low gives ack_o=1; high gives ack_o=0. In both cases err_o=0 and err_code_o=2'b00.
- R7: The STOP holds both lines low for the low time, releases SCL and waits for it to read high, waits the setup-before-STOP time, releases SDA, then waits the bus-free time. done_o is a one-cycle pulse issued with the block idle and both lines released.
- R8: Each phase lasts at least ceil(t_ns / CLK_PERIOD_NS) cycles. fast_i=1 selects the fast timing set (SCL low time 1300 ns instead of 4700 ns).
- R9: If start_i arrives with ten_bit_i=1, done_o follows on the next cycle with err_o=1 and err_code_o=2'b10, and no line is driven.
- R10: A recover_i request never drives SDA. It releases both lines, and done_o comes with err_o=0 as soon as both read high. Before each check after the first, SCL is pulled low once; no pulse is made if the bus is already free.
- R11: If the bus is still not free after RECOVER_PULSES SCL pulses, recovery ends with err_o=1 and err_code_o=2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a quick command (one-cycle pulse, taken when idle) |
| addr_i | input | 7 | Target address |
| rw_i | input | 1 | Read/write bit appended to the address |
| ten_bit_i | input | 1 | Marks the request as ten-bit (refused) |
| fast_i | input | 1 | Selects the fast timing set for the request |
| recover_i | input | 1 | Request bus recovery (taken when idle, start_i has priority) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 1 | Target acknowledged (held until next completion) |
| err_o | output | 1 | Request ended in error (held until next completion) |
| err_code_o | output | 2 | 00 none, 01 stuck bus, 10 ten-bit refused |

## Verification
The quick command is driven with an address that a modelled target owns and with near-miss addresses that differ in one or several bits, under both read and write and both timing sets. This separates a correct acknowledge from one sampled at the wrong moment and shows whether the bit order and the R/W position are right. The measured shortest low and high SCL phases tell the two timing sets apart. A target that stretches the clock briefly must still acknowledge, while one that stretches past the limit, or a clock held low before START, must give the stuck code. Recovery is tried on a free bus, on SDA held for five pulses and on SDA held permanently, which checks the pulse count in all three cases.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FREE_WAIT,
    ST_FREE_BUF,
    ST_START,
    ST_LO1,
    ST_LO2,
    ST_REL,
    ST_HI,
    ST_STOP_LO,
    ST_STOP_REL,
    ST_STOP_SU,
    ST_STOP_BUF,
    ST_REC_CHK,
    ST_REC_LO
  } st_e;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_STUCK = 2'b01;
  localparam logic [1:0] ERR_INVAL = 2'b10;

  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/i2cq_sync.sv
module i2cq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] r_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) r_q[i] <= '1;
    end else begin
      r_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) r_q[i] <= r_q[i-1];
    end
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/i2cq_timer.sv
module i2cq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
  import i2cq_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 4,
  parameter int STRETCH_CYC    = 25000,
  parameter int RECOVER_PULSES = 100,
  parameter int SYNC_STAGES    = 2,
  parameter int STD_HD_NS  = 4000,
  parameter int STD_SU_NS  = 4000,
  parameter int STD_LO_NS  = 4700,
  parameter int STD_HI_NS  = 4000,
  parameter int STD_BUF_NS = 4700,
  parameter int FST_HD_NS  = 600,
  parameter int FST_SU_NS  = 600,
  parameter int FST_LO_NS  = 1300,
  parameter int FST_HI_NS  = 600,
  parameter int FST_BUF_NS = 1300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [6:0] addr_i,
  input  logic       rw_i,
  input  logic       ten_bit_i,
  input  logic       fast_i,
  input  logic       recover_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       ack_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);
  // phase lengths in cycles, index 0 standard, 1 fast
  localparam int HD_C[2]  = '{ns2cyc(STD_HD_NS,  CLK_PERIOD_NS), ns2cyc(FST_HD_NS,  CLK_PERIOD_NS)};
  localparam int SU_C[2]  = '{ns2cyc(STD_SU_NS,  CLK_PERIOD_NS), ns2cyc(FST_SU_NS,  CLK_PERIOD_NS)};
  localparam int LO_C[2]  = '{ns2cyc(STD_LO_NS,  CLK_PERIOD_NS), ns2cyc(FST_LO_NS,  CLK_PERIOD_NS)};
  localparam int HI_C[2]  = '{ns2cyc(STD_HI_NS,  CLK_PERIOD_NS), ns2cyc(FST_HI_NS,  CLK_PERIOD_NS)};
  localparam int BUF_C[2] = '{ns2cyc(STD_BUF_NS, CLK_PERIOD_NS), ns2cyc(FST_BUF_NS, CLK_PERIOD_NS)};
  localparam int MAX_PH = mx(mx(mx(HD_C[0], HD_C[1]), mx(SU_C[0], SU_C[1])),
                             mx(mx(LO_C[0], LO_C[1]),
                                mx(mx(HI_C[0], HI_C[1]) + SYNC_STAGES, mx(BUF_C[0], BUF_C[1]))));
  localparam int CNT_W = $clog2(mx(MAX_PH, STRETCH_CYC) + 1);
  localparam int PW    = $clog2(RECOVER_PULSES + 1);

  st_e             st_q, st_n;
  logic            fast_q, rec_q, ack_smp_q;
  logic [3:0]      bit_q;
  logic [7:0]      sh_q;
  logic [PW-1:0]   pls_q;
  logic            scl_oe_q, sda_oe_q, scl_oe_n, sda_oe_n;
  logic            done_q, ack_q, err_q;
  logic [1:0]      code_q;
  logic            fin_ok, fin_stuck, fin_inval;
  logic            fsel, zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  int              dur_i;
  logic [1:0]      lines_s;
  logic            scl_s, sda_s, free;

  i2cq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({scl_i, sda_i}), .q_o(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];
  assign free  = scl_s & sda_s;

  i2cq_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .zero_o(zero)
  );

  assign fsel = (st_q == ST_IDLE) ? fast_i : fast_q;

  always_comb begin
    st_n      = st_q;
    fin_ok    = 1'b0;
    fin_stuck = 1'b0;
    fin_inval = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (ten_bit_i) fin_inval = 1'b1;
          else           st_n = ST_FREE_WAIT;
        end else if (recover_i) begin
          st_n = ST_REC_CHK;
        end
      end
      ST_FREE_WAIT: begin
        if (free)      st_n = ST_FREE_BUF;
        else if (zero) begin st_n = ST_IDLE; fin_stuck = 1'b1; end
      end
      ST_FREE_BUF: if (zero) st_n = ST_START;
      ST_START:    if (zero) st_n = ST_LO1;
      ST_LO1:      if (zero) st_n = ST_LO2;
      ST_LO2:      if (zero) st_n = ST_REL;
      ST_REL: begin
        if (scl_s)     st_n = ST_HI;
        else if (zero) begin st_n = ST_IDLE; fin_stuck = 1'b1; end
      end
      ST_HI:       if (zero) st_n = (bit_q == 4'd8) ? ST_STOP_LO : ST_LO1;
      ST_STOP_LO:  if (zero) st_n = ST_STOP_REL;
      ST_STOP_REL: begin
        if (scl_s)     st_n = ST_STOP_SU;
        else if (zero) begin st_n = ST_IDLE; fin_stuck = 1'b1; end
      end
      ST_STOP_SU:  if (zero) st_n = ST_STOP_BUF;
      ST_STOP_BUF: if (zero) begin st_n = ST_IDLE; fin_ok = 1'b1; end
      ST_REC_CHK: begin
        if (zero) begin
          if (free) begin
            st_n = ST_IDLE; fin_ok = 1'b1;
          end else if (pls_q == PW'(RECOVER_PULSES)) begin
            st_n = ST_IDLE; fin_stuck = 1'b1;
          end else begin
            st_n = ST_REC_LO;
          end
        end
      end
      ST_REC_LO:   if (zero) st_n = ST_REC_CHK;
      default:     st_n = ST_IDLE;
    endcase

    scl_oe_n = (st_n == ST_LO1) || (st_n == ST_LO2) ||
               (st_n == ST_STOP_LO) || (st_n == ST_REC_LO);
    case (st_n)
      ST_START, ST_STOP_LO, ST_STOP_REL, ST_STOP_SU: sda_oe_n = 1'b1;
      ST_LO1, ST_REL, ST_HI:                         sda_oe_n = sda_oe_q;
      ST_LO2:  sda_oe_n = (bit_q == 4'd8) ? 1'b0 : ~sh_q[7];
      default: sda_oe_n = 1'b0;
    endcase

    case (st_n)
      ST_FREE_WAIT, ST_REL, ST_STOP_REL: dur_i = STRETCH_CYC;
      ST_FREE_BUF, ST_STOP_BUF:          dur_i = BUF_C[fsel];
      ST_START:                          dur_i = HD_C[fsel];
      ST_LO1:                            dur_i = LO_C[fsel] / 2;
      ST_LO2:                            dur_i = LO_C[fsel] - LO_C[fsel] / 2;
      ST_HI:                             dur_i = HI_C[fsel];
      ST_STOP_LO, ST_REC_LO:             dur_i = LO_C[fsel];
      ST_STOP_SU:                        dur_i = SU_C[fsel];
      ST_REC_CHK:                        dur_i = HI_C[fsel] + SYNC_STAGES;
      default:                           dur_i = 0;
    endcase
    tmr_val  = CNT_W'(dur_i);
    tmr_load = (st_n != st_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      done_q    <= 1'b0;
      ack_q     <= 1'b0;
      err_q     <= 1'b0;
      code_q    <= ERR_NONE;
      fast_q    <= 1'b0;
      rec_q     <= 1'b0;
      ack_smp_q <= 1'b0;
      bit_q     <= '0;
      sh_q      <= '0;
      pls_q     <= '0;
    end else begin
      st_q     <= st_n;
      scl_oe_q <= scl_oe_n;
      sda_oe_q <= sda_oe_n;
      done_q   <= fin_ok | fin_stuck | fin_inval;
      if (st_q == ST_IDLE && st_n != ST_IDLE) begin
        fast_q    <= fast_i;
        rec_q     <= (st_n == ST_REC_CHK);
        sh_q      <= {addr_i, rw_i};
        bit_q     <= '0;
        pls_q     <= '0;
        ack_smp_q <= 1'b0;
      end
      if (st_q == ST_HI && st_n == ST_LO1) begin
        bit_q <= bit_q + 1'b1;
        sh_q  <= {sh_q[6:0], 1'b0};
      end
      if (st_q == ST_REL && st_n == ST_HI && bit_q == 4'd8) ack_smp_q <= ~sda_s;
      if (st_q == ST_REC_CHK && st_n == ST_REC_LO) pls_q <= pls_q + 1'b1;
      if (fin_ok) begin
        ack_q  <= ~rec_q & ack_smp_q;
        err_q  <= 1'b0;
        code_q <= ERR_NONE;
      end else if (fin_stuck) begin
        ack_q  <= 1'b0;
        err_q  <= 1'b1;
        code_q <= ERR_STUCK;
      end else if (fin_inval) begin
        ack_q  <= 1'b0;
        err_q  <= 1'b1;
        code_q <= ERR_INVAL;
      end
    end
  end

  assign scl_oe_o   = scl_oe_q;
  assign sda_oe_o   = sda_oe_q;
  assign done_o     = done_q;
  assign ack_o      = ack_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk
  import i2cq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       ten_bit_i,
  input logic       done_o,
  input logic       ack_o,
  input logic       err_o,
  input logic [1:0] err_code_o,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input st_e        st
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!scl_oe_o && !sda_oe_o));

  // R4
  sda_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL || st == ST_HI) |-> $stable(sda_oe_o));

  // R6
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !(ack_o && err_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (st == ST_IDLE));

  // R9
  inval_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start_i && ten_bit_i) |=>
      (done_o && err_o && err_code_o == ERR_INVAL && !scl_oe_o && !sda_oe_o));

  // R10
  rec_no_sda_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REC_CHK || st == ST_REC_LO) |-> !sda_oe_o);
endmodule

bind i2cq_seq i2cq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .ten_bit_i(ten_bit_i),
  .done_o(done_o), .ack_o(ack_o), .err_o(err_o), .err_code_o(err_code_o),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .st(st_q)
);

// File: tb/tb_i2cq_seq.sv
module tb_i2cq_seq;
  localparam int PER_NS = 500;
  localparam int STR    = 40;
  localparam int NPULSE = 100;
  localparam logic [6:0] SLV = 7'h52;
  localparam int LO_STD = 10, LO_FST = 3, HI_STD = 8, HI_FST = 2;

  // {addr, rw, fast}
  localparam logic [8:0] VEC [6] = '{
    {7'h52, 1'b0, 1'b0}, {7'h52, 1'b1, 1'b1}, {7'h13, 1'b0, 1'b0},
    {7'h53, 1'b1, 1'b1}, {7'h2A, 1'b0, 1'b0}, {7'h52, 1'b0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic start_i = 0, rw_i = 0, ten_bit_i = 0, fast_i = 0, recover_i = 0;
  logic [6:0] addr_i = 0;
  logic scl_oe_o, sda_oe_o, done_o, ack_o, err_o;
  logic [1:0] err_code_o;
  logic scl_w, sda_w;

  // bus model controls
  logic force_scl = 0, str_hold = 0, ack_drv = 0, stuck_en = 0, mon_en = 0;
  int stretch_n = 0, str_cnt = 0, stuck_base = 0, stuck_n = 0;
  int scl_rises = 0, scl_falls = 0, starts = 0, bitn = 10, run_len = 0;
  int min_lo = 9999, min_hi = 9999;
  logic [7:0] rxb = 0;
  logic sp = 1, sdp = 1, sda_stuck;

  int n_tests = 0, n_fail = 0;
  int r_n; logic r_done, r_ack, r_err; logic [1:0] r_code;

  always #2 clk = ~clk;

  assign sda_stuck = stuck_en && ((scl_rises - stuck_base) < stuck_n);
  assign scl_w = !(scl_oe_o || force_scl || str_hold);
  assign sda_w = !(sda_oe_o || ack_drv || sda_stuck);

  i2cq_seq #(.CLK_PERIOD_NS(PER_NS), .STRETCH_CYC(STR), .RECOVER_PULSES(NPULSE)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .rw_i(rw_i),
    .ten_bit_i(ten_bit_i), .fast_i(fast_i), .recover_i(recover_i),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .done_o(done_o), .ack_o(ack_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  // target model and line monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (sp && scl_w && sdp && !sda_w) begin
        starts++; bitn = 0; ack_drv = 0; min_lo = 9999; min_hi = 9999;
      end
      if (scl_w != sp) begin
        if (sp) begin if (run_len < min_hi) min_hi = run_len; end
        else    begin if (run_len < min_lo) min_lo = run_len; end
        run_len = 1;
      end else run_len++;
      if (!sp && scl_w) begin
        scl_rises++;
        if (bitn < 8) begin rxb = {rxb[6:0], sda_w}; bitn++; end
      end
      if (sp && !scl_w) begin
        scl_falls++;
        if (stretch_n > 0) str_cnt = stretch_n;
        if (bitn == 8) begin ack_drv = (rxb[7:1] == SLV); bitn = 9; end
        else if (bitn == 9) begin ack_drv = 0; bitn = 10; end
      end
      str_hold = (str_cnt > 0);
      if (str_cnt > 0) str_cnt--;
      sp = scl_w; sdp = sda_w;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    r_n = 0;
    while (!done_o && r_n < 6000) begin @(negedge clk); r_n++; end
    r_done = done_o; r_ack = ack_o; r_err = err_o; r_code = err_code_o;
  endtask

  task automatic run_quick(input logic [6:0] a, input logic rw, input logic f, input logic tb10);
    @(negedge clk);
    addr_i = a; rw_i = rw; fast_i = f; ten_bit_i = tb10; start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done();
  endtask

  task automatic run_rec(input logic f);
    @(negedge clk);
    fast_i = f; recover_i = 1;
    @(negedge clk);
    recover_i = 0;
    wait_done();
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not end, actual 1 expected 0");
    report();
  end

  initial begin
    int s0, f0;
    repeat (4) @(negedge clk);
    // R1: state while held in reset
    chk(!scl_oe_o && !sda_oe_o && !done_o && !ack_o && !err_o, "R1", "reset outputs",
        {scl_oe_o, sda_oe_o, done_o, ack_o, err_o}, 0);
    rst = 0;
    sp = scl_w; sdp = sda_w; mon_en = 1;
    repeat (3) @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o && !done_o && !err_o, "R1", "after reset",
        {scl_oe_o, sda_oe_o, done_o, err_o}, 0);

    // main function: vector table
    for (int v = 0; v < 6; v++) begin
      logic [6:0] a; logic rw, f, exp_ack;
      a = VEC[v][8:2]; rw = VEC[v][1]; f = VEC[v][0];
      exp_ack = (a == SLV);
      s0 = starts;
      run_quick(a, rw, f, 1'b0);
      chk(r_done && !r_err && r_code == 2'b00, "R7", "completion without error", {r_done, r_err}, 2);
      chk(r_ack == exp_ack, "R6", "ack result", r_ack, exp_ack);
      chk(rxb == {a, rw}, "R4", "byte seen on bus", rxb, {a, rw});
      chk(starts - s0 == 1, "R3", "START count", starts - s0, 1);
      chk(!scl_oe_o && !sda_oe_o, "R7", "lines released at done", {scl_oe_o, sda_oe_o}, 0);
      if (f) chk(min_lo >= LO_FST && min_lo < LO_STD && min_hi >= HI_FST, "R8",
                 "fast shortest SCL low", min_lo, LO_FST);
      else   chk(min_lo >= LO_STD && min_hi >= HI_STD, "R8",
                 "standard shortest SCL low", min_lo, LO_STD);
      repeat (30) @(negedge clk);
    end

    // R5: short clock stretching is tolerated
    stretch_n = 15;
    run_quick(SLV, 1'b0, 1'b0, 1'b0);
    chk(r_done && r_ack && !r_err, "R5", "ack under stretching", {r_ack, r_err}, 2);
    chk(rxb == {SLV, 1'b0}, "R5", "byte under stretching", rxb, {SLV, 1'b0});
    stretch_n = 0;
    repeat (40) @(negedge clk);

    // R5: stretching beyond the limit
    stretch_n = 60;
    run_quick(SLV, 1'b1, 1'b0, 1'b0);
    chk(r_done && r_err && r_code == 2'b01, "R5", "stretch timeout code", r_code, 1);
    chk(!scl_oe_o && !sda_oe_o, "R5", "lines released after timeout", {scl_oe_o, sda_oe_o}, 0);
    stretch_n = 0;
    repeat (100) @(negedge clk);

    // R2: clock held low before START
    force_scl = 1;
    s0 = starts;
    run_quick(SLV, 1'b0, 1'b1, 1'b0);
    chk(r_done && r_err && r_code == 2'b01, "R2", "busy bus code", r_code, 1);
    chk(r_n >= STR && r_n <= STR + 4, "R2", "free-wait timeout length", r_n, STR + 1);
    chk(starts == s0, "R2", "no START on busy bus", starts - s0, 0);
    force_scl = 0;
    repeat (20) @(negedge clk);

    // R9: ten-bit request refused
    s0 = starts; f0 = scl_falls;
    run_quick(7'h52, 1'b0, 1'b0, 1'b1);
    chk(r_n == 0 && r_done, "R9", "answer in next cycle", r_n, 0);
    chk(r_err && r_code == 2'b10 && !r_ack, "R9", "invalid code", r_code, 2);
    repeat (5) @(negedge clk);
    chk(starts == s0 && scl_falls == f0 && !scl_oe_o && !sda_oe_o, "R9", "bus untouched",
        (starts - s0) + (scl_falls - f0), 0);
    ten_bit_i = 0;

    // R10: recovery on a free bus
    f0 = scl_falls;
    run_rec(1'b0);
    chk(r_done && !r_err && !r_ack, "R10", "free bus recovery", r_err, 0);
    chk(scl_falls == f0, "R10", "no pulse on free bus", scl_falls - f0, 0);
    repeat (10) @(negedge clk);

    // R10: SDA held for five pulses
    stuck_base = scl_rises; stuck_n = 5; stuck_en = 1;
    f0 = scl_falls;
    run_rec(1'b1);
    chk(r_done && !r_err, "R10", "recovery succeeds", r_err, 0);
    chk(scl_falls - f0 == 5, "R10", "pulse count", scl_falls - f0, 5);
    stuck_en = 0;
    repeat (10) @(negedge clk);

    // R11: SDA held permanently
    stuck_base = scl_rises; stuck_n = 100000; stuck_en = 1;
    f0 = scl_falls;
    run_rec(1'b0);
    chk(r_done && r_err && r_code == 2'b01, "R11", "exhausted recovery code", r_code, 1);
    chk(scl_falls - f0 == NPULSE, "R11", "pulse limit", scl_falls - f0, NPULSE);
    stuck_en = 0;
    repeat (10) @(negedge clk);

    report();
  end
endmodule